// File: doc/BRIEF.md
# Byte-wide SPI transfer engine for a memory card

The block is a CPU-facing SPI master that exchanges one byte with a memory card per transfer. Software sees three byte registers on a small address bus: a data register that holds the byte to send and then the byte received, a control register, and a status register. Software picks one of two trigger modes. In the first, a write of the data register starts a transfer. In the second, a read of the data register returns the last received byte and starts the next transfer, which sends 0xFF. Card commands and their sequencing are handled by software.

The serial clock runs at one of two fixed rates, both derived from the system clock by parameters. Transfers use SPI mode 0, most significant bit first. Software drives the active-low card select directly through a control bit, and the same level drives the activity LED. The card-detect and write-protect inputs come in through a two-flop synchroniser and appear in the status register. The bus has no back-pressure. The busy flag is the only flow control, and a trigger that arrives while it is set is dropped.

Register map: address 0 is data, 1 is control, 2 is status, and 3 reads as zero. Reads are combinational from the address, so `bus_rdata` is valid in the same cycle as `bus_addr`. A strobe acts at the rising clock edge on which it is high.

Top module: `spi_eng_top`

## Requirements
- R1: While reset is asserted and just after it: control reads 0x02 (card deselected, slow rate, write-trigger), status bit0 is 0, `spi_cs_n` and `led_act_n` are 1, `spi_sck` is 0 and `spi_mosi` is 1.
- R2: With control bit6 = 0 and the engine idle, a write to address 0 stores the written byte and sends it. When the transfer ends, address 0 reads the byte received from `spi_miso`.
- R3: With control bit6 = 1 and the engine idle, a read of address 0 returns the last received byte and starts a transfer that sends 0xFF. In this mode a write to address 0 changes nothing and starts nothing.
- R4: Transfers follow SPI mode 0, MSB first. `spi_sck` idles low. `spi_mosi` changes only when a transfer starts or when `spi_sck` falls. `spi_miso` is sampled when `spi_sck` rises. Each high phase of `spi_sck` lasts H system clocks.
- R5: Control bit2 selects H: 1 gives H = CLK_HZ/(2·FAST_HZ) and 0 gives H = CLK_HZ/(2·SLOW_HZ), each at least 1. Busy lasts exactly 16·H cycles, counted from the triggering edge.
- R6: Status bit0 reads 1 from the edge after a trigger until the transfer ends, and 0 otherwise.
- R7: A trigger that arrives while busy is ignored. The transfer in progress, its end time and the data register are not affected.
- R8: `spi_cs_n` and `led_act_n` both follow control bit1, which is written with the control register. Neither output changes at any other time.
- R9: Status bit3 shows `card_absent` and status bit4 shows `card_locked`, each two clocks after the input changes. Both read 1 during reset.
- R10: Control bits 0, 3, 4, 5 and 7 read 0. Status bits 1, 2, 5, 6 and 7 read 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to card |
| spi_miso | input | 1 | Serial data from card |
| spi_cs_n | output | 1 | Card select, active low |
| led_act_n | output | 1 | Activity LED, active low |
| card_absent | input | 1 | 1 when no card is inserted |
| card_locked | input | 1 | 1 when the card is write-protected |

## Verification
The bench builds the engine with CLK_HZ = 16 MHz, FAST_HZ = 8 MHz and SLOW_HZ = 500 kHz. These values give a fast half-period of one clock, the tightest case, where the divider ticks on every cycle and clock edges fall on adjacent cycles. They give a slow half-period of 16 clocks, so the two rates differ clearly in transfer length while a whole run stays short. With these values, triggers that arrive mid-transfer, read-trigger restarts and synchroniser delays can all be compared cycle by cycle against a behavioural model.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] A_DATA = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT = 2'd2;

  // control register bit positions
  localparam int unsigned CTL_CS     = 1;
  localparam int unsigned CTL_FAST   = 2;
  localparam int unsigned CTL_RDTRIG = 6;

  // status register bit positions
  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_NOCARD = 3;
  localparam int unsigned ST_WPROT  = 4;

  localparam logic [REG_DW-1:0] IDLE_TX = 8'hFF;

  typedef struct packed {
    logic rd_trig;
    logic fast;
    logic cs_n;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rd_trig: 1'b0, fast: 1'b0, cs_n: 1'b1};

  // system clocks per half period of the serial clock, never below one
  function automatic int unsigned half_cycles(int unsigned clk_hz, int unsigned sck_hz);
    int unsigned r;
    r = clk_hz / (2 * sck_hz);
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned HALF_SLOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);

  localparam int unsigned HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int unsigned CW   = (HMAX < 2) ? 1 : $clog2(HMAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
  assign tick  = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         tick,
  input  logic         miso,
  output logic         busy,
  output logic         sck,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_word
);

  localparam int unsigned IW = (W < 2) ? 1 : $clog2(W);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;
  logic          smp_q;
  logic          busy_q;
  logic          sck_q;

  assign rx_word = {sh_q[W-2:0], smp_q};
  assign done    = busy_q && tick && sck_q && (idx_q == LAST);
  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = busy_q ? sh_q[W-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      smp_q  <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= tx;
        idx_q  <= '0;
        sck_q  <= 1'b0;
      end
    end else if (tick) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        smp_q <= miso;
      end else begin
        sck_q <= 1'b0;
        sh_q  <= rx_word;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_eng_top.sv
module spi_eng_top
  import spi_eng_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 32_000_000,
  parameter int unsigned FAST_HZ = 8_000_000,
  parameter int unsigned SLOW_HZ = 250_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        led_act_n,
  input  logic        card_absent,
  input  logic        card_locked
);

  localparam int unsigned HALF_FAST = half_cycles(CLK_HZ, FAST_HZ);
  localparam int unsigned HALF_SLOW = half_cycles(CLK_HZ, SLOW_HZ);

  ctrl_t             ctrl_q;
  logic [REG_DW-1:0] data_q;
  logic [REG_DW-1:0] rx_word;
  logic [REG_DW-1:0] tx_byte;
  logic [1:0]        stat_sync;
  logic              busy_w;
  logic              tick_w;
  logic              done_w;
  logic              trig_wr;
  logic              trig_rd;
  logic              start_w;

  assign trig_wr = bus_wr && (bus_addr == A_DATA) && !ctrl_q.rd_trig;
  assign trig_rd = bus_rd && (bus_addr == A_DATA) &&  ctrl_q.rd_trig;
  assign start_w = (trig_wr || trig_rd) && !busy_w;
  assign tx_byte = trig_rd ? IDLE_TX : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (bus_wr && (bus_addr == A_CTRL)) begin
      ctrl_q.cs_n    <= bus_wdata[CTL_CS];
      ctrl_q.fast    <= bus_wdata[CTL_FAST];
      ctrl_q.rd_trig <= bus_wdata[CTL_RDTRIG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (done_w) begin
      data_q <= rx_word;
    end else if (start_w && trig_wr) begin
      data_q <= bus_wdata;
    end
  end

  spi_eng_clkdiv #(
    .HALF_FAST(HALF_FAST),
    .HALF_SLOW(HALF_SLOW)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .fast (ctrl_q.fast),
    .tick (tick_w)
  );

  spi_eng_shifter #(
    .W(REG_DW)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_w),
    .tx     (tx_byte),
    .tick   (tick_w),
    .miso   (spi_miso),
    .busy   (busy_w),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .done   (done_w),
    .rx_word(rx_word)
  );

  spi_eng_sync #(
    .W      (2),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({card_locked, card_absent}),
    .q    (stat_sync)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_DATA: bus_rdata = data_q;
      A_CTRL: begin
        bus_rdata[CTL_CS]     = ctrl_q.cs_n;
        bus_rdata[CTL_FAST]   = ctrl_q.fast;
        bus_rdata[CTL_RDTRIG] = ctrl_q.rd_trig;
      end
      A_STAT: begin
        bus_rdata[ST_BUSY]   = busy_w;
        bus_rdata[ST_NOCARD] = stat_sync[0];
        bus_rdata[ST_WPROT]  = stat_sync[1];
      end
      default: bus_rdata = '0;
    endcase
  end

  assign spi_cs_n  = ctrl_q.cs_n;
  assign led_act_n = ctrl_q.cs_n;

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       busy
);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past((bus_wr || bus_rd) && bus_addr == 2'd0));

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R8
  cs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != $past(spi_cs_n)) |-> $past(bus_wr && bus_addr == 2'd1));

  // R10
  ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> ((bus_rdata & 8'hB9) == 8'h00));

  // R5
  busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

endmodule

bind spi_eng_top spi_eng_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n),
  .busy     (busy_w)
);

// File: tb/spi_eng_top_tb_top.sv
module spi_eng_top_tb_top;

  localparam int unsigned CLK_HZ  = 16_000_000;
  localparam int unsigned FAST_HZ = 8_000_000;
  localparam int unsigned SLOW_HZ = 500_000;
  localparam int HF = CLK_HZ / (2 * FAST_HZ);
  localparam int HS = CLK_HZ / (2 * SLOW_HZ);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_mosi, spi_miso, spi_cs_n, led_act_n;
  logic       card_absent = 1'b0;
  logic       card_locked = 1'b0;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  spi_eng_top #(.CLK_HZ(CLK_HZ), .FAST_HZ(FAST_HZ), .SLOW_HZ(SLOW_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .led_act_n(led_act_n),
    .card_absent(card_absent), .card_locked(card_locked)
  );

  // card model: shifts out on falling SCK, captures MOSI on rising SCK
  logic [7:0] slave_sh = 8'hFF;
  logic [7:0] slave_rx = 8'h00;
  assign spi_miso = slave_sh[7];
  always @(posedge spi_sck) slave_rx <= {slave_rx[6:0], spi_mosi};
  always @(negedge spi_sck) slave_sh <= {slave_sh[6:0], 1'b1};

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int       mbusy = 0;
  logic     m_cs = 1'b1, m_fast = 1'b0, m_rdt = 1'b0;
  int       mdata = 0;
  int       mexp = 0;
  logic     s1c = 1, s2c = 1, s1w = 1, s2w = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; m_cs = 1; m_fast = 0; m_rdt = 0; mdata = 0;
      s1c = 1; s2c = 1; s1w = 1; s2w = 1;
    end else begin
      bit trig;
      trig = (bus_addr == 2'd0) && ((bus_wr && !m_rdt) || (bus_rd && m_rdt));
      if (mbusy != 0) begin
        mbusy--;
        if (mbusy == 0) mdata = mexp;
      end else if (trig) begin
        mbusy = 16 * (m_fast ? HF : HS);
        mexp = slave_sh;
        if (!m_rdt) mdata = bus_wdata;
      end
      if (bus_wr && bus_addr == 2'd1) begin
        m_cs = bus_wdata[1]; m_fast = bus_wdata[2]; m_rdt = bus_wdata[6];
      end
      s2c = s1c; s1c = card_absent;
      s2w = s1w; s1w = card_locked;
    end
  end

  int   hi_len = 0;
  logic prev_sck = 0, prev_mosi = 1;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int expd;
      case (bus_addr)
        2'd0: expd = mdata;
        2'd1: expd = {1'b0, m_rdt, 3'b000, m_fast, m_cs, 1'b0};
        2'd2: expd = {3'b000, s2w, s2c, 2'b00, (mbusy != 0)};
        default: expd = 0;
      endcase
      chk("R6 R9 R10 register read", bus_rdata, expd);
      chk("R8 card select", spi_cs_n, m_cs);
      chk("R8 activity LED", led_act_n, m_cs);
      if (mbusy == 0) chk("R4 idle sck", spi_sck, 0);
      if (prev_sck && spi_sck) chk("R4 mosi stable while sck high", spi_mosi, prev_mosi);
      if (spi_sck) hi_len++;
      else if (hi_len != 0) begin
        chk("R4 sck high phase length", hi_len, m_fast ? HF : HS);
        hi_len = 0;
      end
      prev_sck = spi_sck;
      prev_mosi = spi_mosi;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mbusy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  // write-trigger transfer, measuring busy length through the status register
  task automatic xfer_wr(input logic [7:0] d, input logic [7:0] card, input int h);
    int n;
    @(negedge clk); slave_sh = card;
    @(negedge clk); bus_addr = 2'd0; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 2'd2; #1;
    n = 0;
    while (bus_rdata[0] && n < 10000) begin n++; @(negedge clk); #1; end
    chk("R5 busy length", n, 16 * h);
  endtask

  task automatic xfer_rd(input logic [7:0] card, output logic [7:0] got);
    @(negedge clk); slave_sh = card;
    @(negedge clk); bus_addr = 2'd0; bus_rd = 1; #1; got = bus_rdata;
    @(negedge clk); bus_rd = 0;
    wait_idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    bus_addr = 2'd1; #1;
    chk("R1 control reset", bus_rdata, 8'h02);
    chk("R1 cs_n reset", spi_cs_n, 1);
    chk("R1 led reset", led_act_n, 1);
    chk("R1 sck reset", spi_sck, 0);
    chk("R1 mosi reset", spi_mosi, 1);
    bus_addr = 2'd2; #1;
    chk("R1 status busy reset", bus_rdata[0], 0);
    chk("R9 status sync reset", bus_rdata[4:3], 2'b11);
    @(negedge clk); rst_n = 1;

    // select card, slow, write-trigger
    wr_reg(2'd1, 8'h00);
    @(negedge clk);
    chk("R8 cs_n low after select", spi_cs_n, 0);
    chk("R8 led low after select", led_act_n, 0);

    xfer_wr(8'h3C, 8'hA5, HS);
    wait_idle();
    chk("R2 byte sent", slave_rx, 8'h3C);
    peek(2'd0, v); chk("R2 byte received", v, 8'hA5);

    // trigger while busy is dropped
    @(negedge clk); slave_sh = 8'h5A;
    wr_reg(2'd0, 8'h81);
    repeat (5) @(negedge clk);
    wr_reg(2'd0, 8'hFF);
    peek(2'd0, v); chk("R7 data unchanged by dropped write", v, 8'h81);
    wait_idle();
    chk("R7 original byte sent", slave_rx, 8'h81);
    peek(2'd0, v); chk("R7 received byte", v, 8'h5A);

    // fast rate
    wr_reg(2'd1, 8'h04);
    xfer_wr(8'h96, 8'hC3, HF);
    wait_idle();
    chk("R2 fast byte sent", slave_rx, 8'h96);
    peek(2'd0, v); chk("R2 fast byte received", v, 8'hC3);
    xfer_wr(8'h01, 8'h80, HF);
    wait_idle();
    chk("R4 lsb only sent", slave_rx, 8'h01);
    peek(2'd0, v); chk("R4 msb only received", v, 8'h80);

    // read-trigger, fast
    wr_reg(2'd1, 8'h44);
    xfer_rd(8'h0F, v);
    chk("R3 read returns last byte", v, 8'h80);
    chk("R3 idle byte sent", slave_rx, 8'hFF);
    peek(2'd0, v); chk("R3 received byte", v, 8'h0F);
    wr_reg(2'd0, 8'h12);
    repeat (3) @(negedge clk);
    peek(2'd0, v); chk("R3 write ignored in read mode", v, 8'h0F);
    peek(2'd2, v); chk("R3 write starts nothing", v[0], 0);

    // read-trigger, slow, with a second read while busy
    wr_reg(2'd1, 8'h40);
    @(negedge clk); slave_sh = 8'h6E;
    @(negedge clk); bus_addr = 2'd0; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    repeat (10) @(negedge clk);
    bus_rd = 1; #1; chk("R7 read while busy returns old byte", bus_rdata, 8'h0F);
    @(negedge clk); bus_rd = 0;
    wait_idle();
    peek(2'd0, v); chk("R3 slow read-trigger result", v, 8'h6E);

    // status inputs through the synchroniser
    @(negedge clk); bus_addr = 2'd2; card_absent = 1;
    @(negedge clk); #1; chk("R9 card_absent not yet visible", bus_rdata[3], 0);
    @(negedge clk); #1; chk("R9 card_absent after two clocks", bus_rdata[3], 1);
    card_locked = 1;
    repeat (2) @(negedge clk); #1;
    chk("R9 card_locked after two clocks", bus_rdata[4], 1);

    // reserved bits and unused address
    wr_reg(2'd1, 8'hFF);
    peek(2'd1, v); chk("R10 control reserved bits", v, 8'h46);
    chk("R8 cs_n high after deselect", spi_cs_n, 1);
    wr_reg(2'd2, 8'hFF);
    peek(2'd2, v); chk("R10 status reserved bits", v, 8'h18);
    peek(2'd3, v); chk("R10 unused address", v, 8'h00);
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule